// File: doc/BRIEF.md
# Linked Context Breakpoint Comparator

This block decides whether a linked breakpoint slot, picked by a link number, matches the processor's current execution context. It holds a small bank of per-slot control and value registers, which a simple write port loads. The core drives its exception level, two hypervisor mode bits (`hyp_e2h` for host mode and `hyp_tge` for trap-general) and two context-ID registers, one for EL1 and one for EL2.

A lookup is a one-cycle `lk_valid` strobe together with a 4-bit link number. The block checks three things about the addressed slot: that it exists, that it is context-capable, and that it is enabled. It then uses the slot's type field, the exception level and the mode bits to select one of the two context IDs. The selected context ID is compared for full 32-bit equality with the low half of the slot's value register. The result is registered and appears on `lk_match`, qualified by `lk_done`, one clock after the request.

Top module: `ctx_link_cmp`

## Requirements
- R1: After reset, `lk_done` and `lk_match` are 0 and every control register is zero, so every slot is disabled and no lookup matches.
- R2: `lk_done` is 1 exactly in the cycle after a cycle with `lk_valid` high. `lk_match` is 1 only while `lk_done` is 1.
- R3: A link number at or above `NUM_SLOTS`, or below `NUM_SLOTS - NUM_CTX`, never matches.
- R4: A slot whose control bit 0 (enable) is 0 never matches.
- R5: The type field is control bits [23:20]. For type 3, EL1 (`el`=1) compares against `ctx_el1`. EL0 (`el`=0) compares against `ctx_el2` when both `hyp_e2h` and `hyp_tge` are 1, and against `ctx_el1` otherwise.
- R6: For type 3, EL2 (`el`=2) compares against `ctx_el2` only when `hyp_e2h` is 1 and never matches otherwise. EL3 (`el`=3) never matches.
- R7: Type 7 always compares against `ctx_el1`, and type 13 always compares against `ctx_el2`, whatever the exception level and mode bits.
- R8: Every type value other than 3, 7 and 13 never matches.
- R9: The comparison is full 32-bit equality with bits [31:0] of the slot's value register. Bits [63:32] are ignored, and a difference in any low bit prevents a match.
- R10: A write with `wr_val`=0 loads `wr_data[31:0]` into the control register of slot `wr_idx`. A write with `wr_val`=1 loads `wr_data` into that slot's value register. No other slot changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_val | input | 1 | 0 selects the control register, 1 selects the value register |
| wr_idx | input | 4 | Slot written |
| wr_data | input | 64 | Write data |
| el | input | 2 | Current exception level |
| hyp_e2h | input | 1 | Hypervisor host-mode bit |
| hyp_tge | input | 1 | Hypervisor trap-general bit |
| ctx_el1 | input | 32 | EL1 context ID |
| ctx_el2 | input | 32 | EL2 context ID |
| lk_valid | input | 1 | Lookup request strobe |
| lk_num | input | 4 | Link number of the slot looked up |
| lk_done | output | 1 | Result valid, one cycle after the request |
| lk_match | output | 1 | Linked slot matches the context |

## Verification
The main sweep runs all 16 type codes against every exception level and every combination of the two mode bits. The slot value is set in turn to the EL1 ID, to the EL2 ID, to neither, and to an ID shared by both registers. Comparing the first two cases shows which context ID each combination selects, and the "neither" case shows that equality is required at all. A second sweep runs all 16 link numbers with every slot armed, which separates implemented, context-capable slots from the rest. Further checks flip a single low value bit and change only the upper value bits to confirm the 32-bit comparison width, and clear the enable bit.

// File: rtl/ctx_link_cmp.sv
module ctx_link_cmp #(
  parameter int NUM_SLOTS = 6,
  parameter int NUM_CTX   = 2,
  parameter int LBN_W     = 4,
  parameter int CTRL_W    = 32,
  parameter int VAL_W     = 64,
  parameter int CTX_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_val,
  input  logic [LBN_W-1:0] wr_idx,
  input  logic [VAL_W-1:0] wr_data,
  input  logic [1:0]       el,
  input  logic             hyp_e2h,
  input  logic             hyp_tge,
  input  logic [CTX_W-1:0] ctx_el1,
  input  logic [CTX_W-1:0] ctx_el2,
  input  logic             lk_valid,
  input  logic [LBN_W-1:0] lk_num,
  output logic             lk_done,
  output logic             lk_match
);
  localparam logic [LBN_W:0] SLOTS_L = NUM_SLOTS[LBN_W:0];
  localparam logic [LBN_W:0] FIRST_L = SLOTS_L - NUM_CTX[LBN_W:0];
  localparam logic [3:0] T_CTX_EL  = 4'd3;
  localparam logic [3:0] T_CTX_1   = 4'd7;
  localparam logic [3:0] T_CTX_2   = 4'd13;

  logic [CTRL_W-1:0] ctrl_q [NUM_SLOTS];
  logic [VAL_W-1:0]  val_q  [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    wire hit = wr_en && (wr_idx == g[LBN_W-1:0]);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q[g] <= '0;
        val_q[g]  <= '0;
      end else if (hit) begin
        if (wr_val) val_q[g]  <= wr_data;
        else        ctrl_q[g] <= wr_data[CTRL_W-1:0];
      end
    end
  end

  logic [CTRL_W-1:0] sel_ctrl;
  logic [VAL_W-1:0]  sel_val;
  always_comb begin
    sel_ctrl = '0;
    sel_val  = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (lk_num == i[LBN_W-1:0]) begin
        sel_ctrl = ctrl_q[i];
        sel_val  = val_q[i];
      end
  end

  wire        in_range = ({1'b0, lk_num} < SLOTS_L) && ({1'b0, lk_num} >= FIRST_L);
  wire [3:0]  bt       = sel_ctrl[23:20];
  wire [CTX_W-1:0] val_lo = sel_val[CTX_W-1:0];

  logic             use_ok;
  logic [CTX_W-1:0] cid;
  always_comb begin
    use_ok = 1'b0;
    cid    = ctx_el1;
    unique case (bt)
      T_CTX_EL: begin
        unique case (el)
          2'd3: use_ok = 1'b0;
          2'd2: begin use_ok = hyp_e2h; cid = ctx_el2; end
          2'd1: begin use_ok = 1'b1;    cid = ctx_el1; end
          default: begin
            use_ok = 1'b1;
            cid    = (hyp_e2h && hyp_tge) ? ctx_el2 : ctx_el1;
          end
        endcase
      end
      T_CTX_1: begin use_ok = 1'b1; cid = ctx_el1; end
      T_CTX_2: begin use_ok = 1'b1; cid = ctx_el2; end
      default: use_ok = 1'b0;
    endcase
  end

  wire hit_now = in_range && sel_ctrl[0] && use_ok && (cid == val_lo);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_done  <= 1'b0;
      lk_match <= 1'b0;
    end else begin
      lk_done  <= lk_valid;
      lk_match <= lk_valid && hit_now;
    end
  end
endmodule

// File: rtl/ctx_link_cmp_chk.sv
module ctx_link_cmp_chk #(
  parameter int NUM_SLOTS = 6,
  parameter int NUM_CTX   = 2,
  parameter int LBN_W     = 4,
  parameter int CTX_W     = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [LBN_W-1:0] lk_num,
  input logic             lk_done,
  input logic             lk_match,
  input logic [1:0]       el,
  input logic             hyp_e2h,
  input logic [3:0]       bt,
  input logic [CTX_W-1:0] val_lo,
  input logic [CTX_W-1:0] ctx_el2
);
  wire out_rng = (int'(lk_num) >= NUM_SLOTS) || (int'(lk_num) < NUM_SLOTS - NUM_CTX);

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_done); // R2
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_done); // R2
  AST_MATCH_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    lk_match |-> lk_done); // R2
  AST_RANGE_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && out_rng) |=> !lk_match); // R3
  AST_EL3_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && bt == 4'd3 && el == 2'd3) |=> !lk_match); // R6
  AST_EL2_NEEDS_E2H: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && bt == 4'd3 && el == 2'd2 && !hyp_e2h) |=> !lk_match); // R6
  AST_T13_EL2_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && bt == 4'd13 && val_lo != ctx_el2) |=> !lk_match); // R7
  AST_RESERVED_TYPES: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && bt != 4'd3 && bt != 4'd7 && bt != 4'd13) |=> !lk_match); // R8
endmodule

bind ctx_link_cmp ctx_link_cmp_chk #(
  .NUM_SLOTS(NUM_SLOTS), .NUM_CTX(NUM_CTX), .LBN_W(LBN_W), .CTX_W(CTX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_num(lk_num),
  .lk_done(lk_done), .lk_match(lk_match), .el(el), .hyp_e2h(hyp_e2h),
  .bt(bt), .val_lo(val_lo), .ctx_el2(ctx_el2)
);

// File: tb/ctx_link_cmp_tb_top.sv
module ctx_link_cmp_tb_top;
  localparam int NS = 6;
  localparam int NC = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_val = 0;
  logic [3:0] wr_idx = 0;
  logic [63:0] wr_data = 0;
  logic [1:0] el = 0;
  logic hyp_e2h = 0, hyp_tge = 0;
  logic [31:0] ctx_el1 = 0, ctx_el2 = 0;
  logic lk_valid = 0;
  logic [3:0] lk_num = 0;
  logic lk_done, lk_match;
  int tests = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  ctx_link_cmp #(.NUM_SLOTS(NS), .NUM_CTX(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_val(wr_val), .wr_idx(wr_idx),
    .wr_data(wr_data), .el(el), .hyp_e2h(hyp_e2h), .hyp_tge(hyp_tge),
    .ctx_el1(ctx_el1), .ctx_el2(ctx_el2), .lk_valid(lk_valid), .lk_num(lk_num),
    .lk_done(lk_done), .lk_match(lk_match));

  task automatic check(input bit act, input bit exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr(input bit isval, input int idx, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_val = isval; wr_idx = idx[3:0]; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input int n, input bit exp, input string req);
    @(negedge clk);
    lk_valid = 1; lk_num = n[3:0];
    @(negedge clk);
    lk_valid = 0;
    check(lk_done, 1'b1, "R2");
    check(lk_match, exp, req);
    @(negedge clk);
    check(lk_done, 1'b0, "R2");
  endtask

  function automatic bit model(input int t, input int e, input bit h, input bit g,
                               input logic [31:0] v, input logic [31:0] c1,
                               input logic [31:0] c2);
    if (t == 7) return v == c1;
    if (t == 13) return v == c2;
    if (t != 3) return 0;
    if (e == 3) return 0;
    if (e == 2) return h && (v == c2);
    if (e == 1) return v == c1;
    return (h && g) ? (v == c2) : (v == c1);
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++; tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] pv;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(lk_done, 1'b0, "R1");
    check(lk_match, 1'b0, "R1");
    look(4, 1'b0, "R1");
    look(5, 1'b0, "R1");

    // R5 R6 R7 R8 sweep on slot 5
    ctx_el1 = 32'h1111_0001; ctx_el2 = 32'h2222_0002;
    for (int p = 0; p < 4; p++) begin
      if (p == 3) ctx_el2 = ctx_el1;
      pv = (p == 0) ? ctx_el1 : (p == 1) ? ctx_el2 : (p == 2) ? 32'h3333_0003 : ctx_el1;
      wr(1, 5, {32'hDEAD_0000, pv});
      for (int t = 0; t < 16; t++) begin
        wr(0, 5, 64'(1 | (t << 20)));
        for (int e = 0; e < 4; e++)
          for (int m = 0; m < 4; m++) begin
            el = e[1:0]; hyp_e2h = m[0]; hyp_tge = m[1];
            look(5, model(t, e, m[0], m[1], pv, ctx_el1, ctx_el2),
                 (t == 3) ? ((e >= 2) ? "R6" : "R5") :
                 (t == 7 || t == 13) ? "R7" : "R8");
          end
      end
    end

    // R3 range sweep, every slot armed type 7 matching
    ctx_el2 = 32'h2222_0002; el = 1;
    for (int s = 0; s < 16; s++) begin
      wr(1, s, {32'h0, ctx_el1});
      wr(0, s, 64'h0070_0001);
    end
    for (int n = 0; n < 16; n++)
      look(n, (n >= NS - NC) && (n < NS), "R3");

    // R4 enable clear
    wr(0, 4, 64'h0070_0000);
    look(4, 1'b0, "R4");
    look(5, 1'b1, "R10");
    wr(0, 4, 64'h0070_0001);
    look(4, 1'b1, "R10");

    // R9 width of comparison
    wr(1, 4, {32'h0, ctx_el1 ^ 32'h8000_0000});
    look(4, 1'b0, "R9");
    wr(1, 4, {32'hFFFF_FFFF, ctx_el1 ^ 32'h0000_0001});
    look(4, 1'b0, "R9");
    wr(1, 4, {32'hFFFF_FFFF, ctx_el1});
    look(4, 1'b1, "R9");
    look(5, 1'b1, "R10");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule